// File: doc/BRIEF.md
# Sense-Controlled Interrupt Controller

This block gathers interrupt requests for a single processor. It takes a bank of on-chip request lines and up to eight board-level pins. Every request line is active low. Each board pin has its own sense setting: the pin is either followed as a low level, or its high-to-low transitions are captured in a sticky pending bit that software acknowledges. The on-chip lines are always treated as low-level requests.

Masks gate which requests take part. The enabled request with the lowest source number is published as a 7-bit vector, and the interrupt output is raised while that vector is non-zero. Board pin 0 can be steered away from the normal path and onto a machine-check output. That output latches a sticky status bit and has its own disable.

Software reaches the block through a word-wide register port. Writes take effect at the clock edge and reads are combinational from the address. All register bit positions count from the most significant end.

Top module: `irq_sense_ctrl`

## Requirements
- R1: After reset the internal mask (address 0), the external mask (address 1), the sense register (address 2) and the machine-check control (address 5) all read 0. The vector (address 4) reads 0, and both `irq_o` and `mchk_o` are low.
- R2: Bit numbering is MSB-first. Internal source i is enabled by bit 31−i of address 0. Only the top N_INT bits are implemented and the other bits read 0. External pin k is enabled by bit 31−k of address 1. External pin k reports its pending state in bit 31−k of address 3. A mask bit of 1 enables.
- R3: In the sense register, pin 0 uses bit 15 and pin k uses bit 15−k. A value of 1 selects falling-edge sensing and 0 selects low-level sensing. All other bits of the sense register read 0.
- R4: A level-mode external pin is pending while its twice-synchronized value is low. It appears two clock edges after the pin changes and needs no acknowledge. Internal sources are never synchronized: each is a request while its input is low.
- R5: An edge-mode pin latches pending on the edge after its synchronized value falls from 1 to 0, which is three edges after the pin changes. It stays pending until a write to address 3 carries a 1 in its bit. Writing 0 bits leaves it pending.
- R6: If a clear write and a newly detected falling edge hit the same pin in the same cycle, the pin stays pending.
- R7: Source numbers are k+1 for external pin k and N_EXT+1+i for internal source i. The vector register gives, in its low 7 bits, the lowest source number that is both requesting and enabled. A value of 0 means no such source.
- R8: `irq_o` is high exactly when the vector is non-zero.
- R9: Bit 0 of address 1 steers pin 0 to the machine-check path. While this bit is set, pin 0 never appears in the vector. While it is set and pin 0 is pending, bit 31 of the machine-check status (address 6) is set on the next edge.
- R10: `mchk_o` follows the status bit unless bit 0 of address 5 is 1, which forces it low. Writing a 1 to bit 31 of address 6 clears the status bit, but a set condition in the same cycle wins.
- R11: A rising transition on an edge-mode pin never makes it pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for `addr_i` |
| int_src_ni | input | N_INT | Internal requests, active low |
| ext_pin_ni | input | N_EXT | External pins, active low, asynchronous |
| irq_o | output | 1 | Interrupt request to the processor |
| mchk_o | output | 1 | Machine-check request |

## Verification
A pending bit that is lost or stuck shows up in the pending register and the vector in the very cycle after it should have changed. Each check therefore samples at the exact edge count implied by the two-flop synchronizer and the pending register. A wrong priority order or a broken mask gives a wrong vector number at once, while several sources are active together. A fault in machine-check routing shows up in two ways: pin 0 leaks into the vector, or status and `mchk_o` fail to follow the route, disable and clear rules. Both are visible one edge after the pin is seen.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;

    localparam int REG_AW  = 3;
    localparam int DATA_W  = 32;
    localparam int VEC_W   = 7;
    localparam int MAX_EXT = 8;

    // bit positions the behaviour depends on
    localparam int ROUTE_BIT   = 0;
    localparam int MC_DIS_BIT  = 0;
    localparam int MC_STAT_BIT = 31;
    localparam int SENSE_TOP   = 15;

    typedef enum logic [REG_AW-1:0] {
        A_INT_MASK = 3'd0,
        A_EXT_MASK = 3'd1,
        A_SENSE    = 3'd2,
        A_EXT_PEND = 3'd3,
        A_VECTOR   = 3'd4,
        A_MC_CTRL  = 3'd5,
        A_MC_STAT  = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic [DATA_W-1:0]  int_mask;   // register order, bit 31 = source 0
        logic [MAX_EXT-1:0] ext_mask;   // pin order
        logic               route;
        logic [MAX_EXT-1:0] sense;      // pin order, 1 = falling edge
        logic [MAX_EXT-1:0] edge_pend;  // pin order
        logic               mc_dis;
        logic               mc_stat;
    } ctl_state_t;

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] pin_ni,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] fall_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.s1   = pin_ni;
        s_d.s2   = s_q.s1;
        s_d.prev = s_q.s2;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign lvl_o  = s_q.s2;
    assign fall_o = s_q.prev & ~s_q.s2;

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N  = 24,
    parameter int VW = 7
) (
    input  logic [N-1:0]  req_i,
    output logic [VW-1:0] vec_o
);

    always_comb begin
        vec_o = '0;
        for (int j = N - 1; j >= 0; j--) begin
            if (req_i[j]) begin
                vec_o = VW'(j + 1);
            end
        end
    end

endmodule

// File: rtl/irq_sense_ctrl.sv
module irq_sense_ctrl
    import irq_sense_pkg::*;
#(
    parameter int N_INT = 16,
    parameter int N_EXT = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [REG_AW-1:0] addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic [N_INT-1:0]  int_src_ni,
    input  logic [N_EXT-1:0]  ext_pin_ni,
    output logic              irq_o,
    output logic              mchk_o
);

    localparam int N_SRC = N_EXT + N_INT;
    localparam logic [DATA_W-1:0] INT_IMPL = ~({DATA_W{1'b1}} >> N_INT);

    ctl_state_t s_d, s_q;

    logic [N_EXT-1:0] sync_lvl, fall;
    logic [N_EXT-1:0] ext_active, ext_req;
    logic [N_INT-1:0] int_req;
    logic [N_SRC-1:0] req;
    logic [VEC_W-1:0] vec;
    logic             wr_int_mask, wr_ext_mask, wr_sense, wr_pend, wr_mc_ctrl, wr_mc_stat;

    irq_pin_sync #(.W(N_EXT)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_ni (ext_pin_ni),
        .lvl_o  (sync_lvl),
        .fall_o (fall)
    );

    // request vector: externals first so they take the low numbers
    always_comb begin
        for (int k = 0; k < N_EXT; k++) begin
            ext_active[k] = s_q.sense[k] ? s_q.edge_pend[k] : ~sync_lvl[k];
            ext_req[k]    = ext_active[k] & s_q.ext_mask[k];
        end
        if (s_q.route) begin
            ext_req[0] = 1'b0;
        end
        for (int i = 0; i < N_INT; i++) begin
            int_req[i] = ~int_src_ni[i] & s_q.int_mask[DATA_W-1-i];
        end
        req = {int_req, ext_req};
    end

    irq_prio_enc #(.N(N_SRC), .VW(VEC_W)) u_enc (
        .req_i (req),
        .vec_o (vec)
    );

    assign wr_int_mask = wr_en_i && (addr_i == A_INT_MASK);
    assign wr_ext_mask = wr_en_i && (addr_i == A_EXT_MASK);
    assign wr_sense    = wr_en_i && (addr_i == A_SENSE);
    assign wr_pend     = wr_en_i && (addr_i == A_EXT_PEND);
    assign wr_mc_ctrl  = wr_en_i && (addr_i == A_MC_CTRL);
    assign wr_mc_stat  = wr_en_i && (addr_i == A_MC_STAT);

    always_comb begin
        s_d = s_q;
        if (wr_int_mask) begin
            s_d.int_mask = wr_data_i & INT_IMPL;
        end
        if (wr_ext_mask) begin
            for (int k = 0; k < N_EXT; k++) begin
                s_d.ext_mask[k] = wr_data_i[DATA_W-1-k];
            end
            s_d.route = wr_data_i[ROUTE_BIT];
        end
        if (wr_sense) begin
            for (int k = 0; k < N_EXT; k++) begin
                s_d.sense[k] = wr_data_i[SENSE_TOP-k];
            end
        end
        // sticky edge capture, write-one-to-clear, new edge wins
        for (int k = 0; k < N_EXT; k++) begin
            if (s_q.sense[k]) begin
                s_d.edge_pend[k] = fall[k] |
                    (s_q.edge_pend[k] & ~(wr_pend & wr_data_i[DATA_W-1-k]));
            end else begin
                s_d.edge_pend[k] = 1'b0;
            end
        end
        if (wr_mc_ctrl) begin
            s_d.mc_dis = wr_data_i[MC_DIS_BIT];
        end
        s_d.mc_stat = (s_q.route & ext_active[0]) |
                      (s_q.mc_stat & ~(wr_mc_stat & wr_data_i[MC_STAT_BIT]));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        case (addr_i)
            A_INT_MASK: rd_data_o = s_q.int_mask;
            A_EXT_MASK: begin
                for (int k = 0; k < N_EXT; k++) begin
                    rd_data_o[DATA_W-1-k] = s_q.ext_mask[k];
                end
                rd_data_o[ROUTE_BIT] = s_q.route;
            end
            A_SENSE: begin
                for (int k = 0; k < N_EXT; k++) begin
                    rd_data_o[SENSE_TOP-k] = s_q.sense[k];
                end
            end
            A_EXT_PEND: begin
                for (int k = 0; k < N_EXT; k++) begin
                    rd_data_o[DATA_W-1-k] = ext_active[k];
                end
            end
            A_VECTOR:  rd_data_o[VEC_W-1:0] = vec;
            A_MC_CTRL: rd_data_o[MC_DIS_BIT] = s_q.mc_dis;
            A_MC_STAT: rd_data_o[MC_STAT_BIT] = s_q.mc_stat;
            default:   rd_data_o = '0;
        endcase
    end

    assign irq_o  = (vec != '0);
    assign mchk_o = s_q.mc_stat & ~s_q.mc_dis;

    // ---------------- assertions ----------------
    generate
        for (genvar k = 0; k < N_EXT; k++) begin : g_pend_chk
            AST_EDGE_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (s_q.sense[k] && s_q.edge_pend[k] && !wr_sense &&
                 !(wr_pend && wr_data_i[DATA_W-1-k])) |=> s_q.edge_pend[k]); // R5
        end
    endgenerate

    AST_ROUTED_PIN_HIDDEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.route |-> (vec != VEC_W'(1))); // R9

    AST_MC_STAT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.mc_stat && !(wr_mc_stat && wr_data_i[MC_STAT_BIT])) |=> s_q.mc_stat); // R10

    AST_VEC_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vec != '0) |-> (req[vec - VEC_W'(1)] &&
            ((req & ((N_SRC'(1) << (vec - VEC_W'(1))) - N_SRC'(1))) == '0))); // R7

    AST_EXT_VEC_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((vec != '0) && (vec <= VEC_W'(N_EXT))) |-> s_q.ext_mask[3'(vec - VEC_W'(1))]); // R7

endmodule

// File: tb/test_irq_sense_ctrl.sv
module test_irq_sense_ctrl;

    localparam int N_INT = 16;
    localparam int N_EXT = 8;

    logic              clk_i = 1'b0;
    logic              rst_ni = 1'b0;
    logic              wr_en_i = 1'b0;
    logic [2:0]        addr_i = '0;
    logic [31:0]       wr_data_i = '0;
    logic [31:0]       rd_data_o;
    logic [N_INT-1:0]  int_src_ni = '1;
    logic [N_EXT-1:0]  ext_pin_ni = '1;
    logic              irq_o, mchk_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] rv;

    localparam logic [2:0] AD_IMASK = 3'd0, AD_EMASK = 3'd1, AD_SENSE = 3'd2,
                           AD_PEND = 3'd3, AD_VEC = 3'd4, AD_MCC = 3'd5, AD_MCS = 3'd6;

    irq_sense_ctrl #(.N_INT(N_INT), .N_EXT(N_EXT)) i_irq_sense_ctrl (
        .clk_i, .rst_ni, .wr_en_i, .addr_i, .wr_data_i, .rd_data_o,
        .int_src_ni, .ext_pin_ni, .irq_o, .mchk_o
    );

    always #4 clk_i = ~clk_i;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a negedge; commits on the following posedge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en_i = 1'b1; addr_i = a; wr_data_i = d;
        @(posedge clk_i);
        @(negedge clk_i);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr_i = a;
        #1;
        d = rd_data_o;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk_i);
    endtask

    task automatic tsk_reset;
        rd(AD_IMASK, rv); chk("R1 int mask", rv, 32'h0);
        rd(AD_EMASK, rv); chk("R1 ext mask", rv, 32'h0);
        rd(AD_SENSE, rv); chk("R1 sense", rv, 32'h0);
        rd(AD_MCC, rv);   chk("R1 mc ctrl", rv, 32'h0);
        rd(AD_VEC, rv);   chk("R1 vector", rv, 32'h0);
        chk("R1 irq_o", {31'b0, irq_o}, 32'h0);
        chk("R1 mchk_o", {31'b0, mchk_o}, 32'h0);
    endtask

    task automatic tsk_bitmap;
        wr(AD_IMASK, 32'hFFFF_FFFF);
        rd(AD_IMASK, rv); chk("R2 int mask implemented bits", rv, 32'hFFFF_0000);
        wr(AD_EMASK, 32'hFFFF_FFFF);
        rd(AD_EMASK, rv); chk("R2 ext mask layout", rv, 32'hFF00_0001);
        wr(AD_SENSE, 32'hFFFF_FFFF);
        rd(AD_SENSE, rv); chk("R3 sense layout", rv, 32'h0000_FF00);
        wr(AD_SENSE, 32'h0000_8000);
        rd(AD_SENSE, rv); chk("R3 pin0 sense bit 15", rv, 32'h0000_8000);
        wr(AD_IMASK, 32'h0);
        wr(AD_EMASK, 32'h0);
        wr(AD_SENSE, 32'h0);
    endtask

    task automatic tsk_level;
        wr(AD_EMASK, 32'h1000_0000);          // pin 3
        ext_pin_ni[3] = 1'b0;
        idle(1);
        rd(AD_PEND, rv); chk("R4 level not yet through synchronizer", rv, 32'h0);
        idle(1);
        rd(AD_PEND, rv); chk("R4 level pending after two edges", rv, 32'h1000_0000);
        rd(AD_VEC, rv);  chk("R4 level vector", rv, 32'd4);
        ext_pin_ni[3] = 1'b1;
        idle(2);
        rd(AD_PEND, rv); chk("R4 level follows input, no ack", rv, 32'h0);
        rd(AD_VEC, rv);  chk("R4 vector back to 0", rv, 32'h0);
        wr(AD_EMASK, 32'h0);
        wr(AD_IMASK, 32'h2000_0000);          // internal 2
        int_src_ni[2] = 1'b0;
        idle(1);
        rd(AD_VEC, rv);  chk("R4 internal low-level request", rv, 32'd11);
        int_src_ni[2] = 1'b1;
        idle(1);
        rd(AD_VEC, rv);  chk("R4 internal released", rv, 32'h0);
        wr(AD_IMASK, 32'h0);
    endtask

    task automatic tsk_edge;
        wr(AD_SENSE, 32'h0000_0400);          // pin 5 edge
        wr(AD_EMASK, 32'h0400_0000);
        ext_pin_ni[5] = 1'b0;
        idle(2);
        rd(AD_PEND, rv); chk("R5 edge not latched before third edge", rv, 32'h0);
        idle(1);
        rd(AD_PEND, rv); chk("R5 edge latched", rv, 32'h0400_0000);
        rd(AD_VEC, rv);  chk("R5 edge vector", rv, 32'd6);
        wr(AD_PEND, 32'hFBFF_FFFF);
        rd(AD_PEND, rv); chk("R5 zero bit write keeps pending", rv, 32'h0400_0000);
        wr(AD_PEND, 32'h0400_0000);
        rd(AD_PEND, rv); chk("R5 write one clears", rv, 32'h0);
        ext_pin_ni[5] = 1'b1;
        idle(4);
        rd(AD_PEND, rv); chk("R11 rising edge does not latch", rv, 32'h0);
        rd(AD_VEC, rv);  chk("R11 vector stays 0", rv, 32'h0);
        ext_pin_ni[5] = 1'b0;
        idle(3);
        ext_pin_ni[5] = 1'b1;
        idle(4);
        rd(AD_PEND, rv); chk("R5 sticky after pin returns high", rv, 32'h0400_0000);
        wr(AD_PEND, 32'h0400_0000);
    endtask

    task automatic tsk_race;
        ext_pin_ni[5] = 1'b0;
        idle(2);                              // fall seen, latches next edge
        wr(AD_PEND, 32'h0400_0000);
        rd(AD_PEND, rv); chk("R6 new edge beats clear", rv, 32'h0400_0000);
        wr(AD_PEND, 32'h0400_0000);
        rd(AD_PEND, rv); chk("R6 later clear works", rv, 32'h0);
        ext_pin_ni[5] = 1'b1;
        idle(3);
        wr(AD_SENSE, 32'h0);
        wr(AD_EMASK, 32'h0);
    endtask

    task automatic tsk_priority;
        wr(AD_IMASK, 32'h2400_0000);          // internal 2 and 5
        int_src_ni[2] = 1'b0; int_src_ni[5] = 1'b0;
        idle(1);
        rd(AD_VEC, rv); chk("R7 lowest internal wins", rv, 32'd11);
        chk("R8 irq_o with vector", {31'b0, irq_o}, 32'h1);
        wr(AD_IMASK, 32'h0400_0000);
        rd(AD_VEC, rv); chk("R7 masked source skipped", rv, 32'd14);
        wr(AD_EMASK, 32'h1000_0000);
        ext_pin_ni[3] = 1'b0;
        idle(2);
        rd(AD_VEC, rv); chk("R7 external beats internal", rv, 32'd4);
        wr(AD_EMASK, 32'h0);
        rd(AD_VEC, rv); chk("R7 masked external ignored", rv, 32'd14);
        int_src_ni = '1; ext_pin_ni = '1;
        idle(3);
        rd(AD_VEC, rv); chk("R7 nothing pending", rv, 32'h0);
        chk("R8 irq_o low with zero vector", {31'b0, irq_o}, 32'h0);
        wr(AD_IMASK, 32'h0);
    endtask

    task automatic tsk_mchk;
        wr(AD_EMASK, 32'h8000_0001);          // pin 0 enabled and routed
        ext_pin_ni[0] = 1'b0;
        idle(3);
        rd(AD_MCS, rv); chk("R9 routed pin sets status", rv, 32'h8000_0000);
        rd(AD_VEC, rv); chk("R9 routed pin not in vector", rv, 32'h0);
        chk("R9 irq_o low when routed", {31'b0, irq_o}, 32'h0);
        chk("R10 mchk_o high", {31'b0, mchk_o}, 32'h1);
        wr(AD_MCC, 32'h1);
        chk("R10 disable blocks mchk_o", {31'b0, mchk_o}, 32'h0);
        rd(AD_MCS, rv); chk("R10 status kept while disabled", rv, 32'h8000_0000);
        wr(AD_MCS, 32'h8000_0000);
        rd(AD_MCS, rv); chk("R10 set wins over clear", rv, 32'h8000_0000);
        ext_pin_ni[0] = 1'b1;
        idle(3);
        wr(AD_MCS, 32'h8000_0000);
        rd(AD_MCS, rv); chk("R10 write one clears status", rv, 32'h0);
        wr(AD_MCC, 32'h0);
        wr(AD_EMASK, 32'h8000_0000);          // unrouted
        ext_pin_ni[0] = 1'b0;
        idle(2);
        rd(AD_VEC, rv); chk("R9 unrouted pin 0 gives vector 1", rv, 32'd1);
        chk("R9 no machine check when unrouted", {31'b0, mchk_o}, 32'h0);
        ext_pin_ni[0] = 1'b1;
        idle(3);
    endtask

    initial begin
        #(8 * 100000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_ni = 1'b1;
        idle(1);
        tsk_reset();
        tsk_bitmap();
        tsk_level();
        tsk_edge();
        tsk_race();
        tsk_priority();
        tsk_mchk();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule